// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a multi-plane nonvolatile array. While the array's operation controller runs an internal program or erase, a read aimed at the busy plane must not return array contents. It must return a status word that software polls to find out when the operation has finished. On every read strobe the block looks up the plane and sector of the read address, classifies the read against that plane's state, and returns one of two things one cycle later: the array word taken from an external data input, or a status word.

The status word carries three flags. The poll flag on bit 7 tells software whether the operation is still running. The primary toggle on bit 6 inverts on every read of a busy plane. The auxiliary toggle on bit 2 shows an erase, or a read of a sector whose erase is suspended. All other bit positions still carry the array word. The block keeps one toggle flip-flop per plane, so polling one plane does not disturb the toggle sequence seen by another. It also drives an active-low ready/busy level, which is low while any plane runs an internal operation.

Top module: `opstat_reporter`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is all zeros, `busy_n` is 1, and every plane's toggle state is 0.
- R2: The plane of a read is the top `PLANE_BITS` bits of `rd_addr` (bit 19 with defaults). Its sector is `rd_addr[ADDR_W-1:SECTOR_SHIFT]` (bits 19..15 with defaults).
- R3: A read of a plane whose `plane_prog` bit is set returns the complement of `prog_data[7]` on bit 7 and 1 on bit 2.
- R4: A read of a plane whose `plane_erase` bit is set, and whose `plane_prog` bit is clear, returns 0 on bit 7 and the plane's toggle state on bit 2.
- R5: In the program and erase cases, bit 6 returns the plane's toggle state. Each such read then inverts that plane's toggle state, and the other planes keep theirs. The first status read after reset returns 0 on bit 6.
- R6: A read of a plane with no flag set returns `arr_data` unchanged and leaves every toggle state as it was.
- R7: A read that hits `susp_sector` in a plane whose `plane_susp` bit is set, with neither the program flag nor the erase flag of that plane set, returns 1 on bit 7, 1 on bit 6 and the toggle state on bit 2. It then inverts that plane's toggle state.
- R8: In that suspended plane, a read of any other sector returns `arr_data` unchanged and leaves the toggle state as it was.
- R9: In every status word, the bits other than 7, 6 and 2 carry `arr_data`.
- R10: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` holds the word for that read until the next read.
- R11: `busy_n` is 0 in the cycle after any cycle in which a `plane_prog` or `plane_erase` bit is set. It is 1 in the cycle after a cycle in which all of those bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Word address of the read |
| arr_data | input | DATA_W | Array word at `rd_addr`, valid with `rd_en` |
| plane_prog | input | 2**PLANE_BITS | Per-plane internal program in progress |
| plane_erase | input | 2**PLANE_BITS | Per-plane internal erase in progress |
| plane_susp | input | 2**PLANE_BITS | Per-plane erase suspended |
| prog_data | input | DATA_W | Word loaded by the current program |
| susp_sector | input | ADDR_W-SECTOR_SHIFT | Sector number of the suspended erase |
| rd_data | output | DATA_W | Returned word, array or status |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| busy_n | output | 1 | Low while any plane programs or erases |

## Verification
A toggle flip-flop that is wrong, or that belongs to the wrong plane, has no effect until the next status read of that plane. At that read, bit 6, or bit 2 during an erase or a suspended-sector read, comes out inverted. The check therefore only detects such a fault once the bench models each plane's toggle state across long runs of mixed reads. A wrong read classification corrupts bit 7 or passes array data through on the very read concerned, and a wrong busy register shows on `busy_n` one cycle after the flags change.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
   typedef enum logic [1:0] {
      MODE_ARRAY = 2'd0,
      MODE_PROG  = 2'd1,
      MODE_ERASE = 2'd2,
      MODE_SUSP  = 2'd3
   } rd_mode_e;
endpackage

// File: rtl/opstat_plane_decode.sv
module opstat_plane_decode
   import opstat_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int PLANE_BITS   = 1,
   parameter int SECTOR_SHIFT = 15,
   localparam int NP          = 1 << PLANE_BITS,
   localparam int PIDX_W      = (PLANE_BITS > 0) ? PLANE_BITS : 1,
   localparam int SECT_W      = ADDR_W - SECTOR_SHIFT
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [SECT_W-1:0] susp_sector,
   input  logic [NP-1:0]     plane_prog,
   input  logic [NP-1:0]     plane_erase,
   input  logic [NP-1:0]     plane_susp,
   output logic [PIDX_W-1:0] plane_idx,
   output rd_mode_e          mode
);
   logic sect_hit;

   generate
      if (PLANE_BITS == 0) begin : g_one_plane
         assign plane_idx = '0;
      end else begin : g_multi_plane
         assign plane_idx = rd_addr[ADDR_W-1 -: PLANE_BITS];
      end
   endgenerate

   assign sect_hit = (rd_addr[ADDR_W-1:SECTOR_SHIFT] == susp_sector);

   // program outranks erase, erase outranks a suspended-sector read
   always_comb begin
      if (plane_prog[plane_idx])
         mode = MODE_PROG;
      else if (plane_erase[plane_idx])
         mode = MODE_ERASE;
      else if (plane_susp[plane_idx] && sect_hit)
         mode = MODE_SUSP;
      else
         mode = MODE_ARRAY;
   end
endmodule

// File: rtl/opstat_toggle_bank.sv
module opstat_toggle_bank #(
   parameter int NP     = 2,
   parameter int PIDX_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_en,
   input  logic [PIDX_W-1:0] adv_idx,
   output logic [NP-1:0]     tog_q
);
   generate
      for (genvar i = 0; i < NP; i++) begin : g_plane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tog_q[i] <= 1'b0;
            else if (adv_en && (adv_idx == PIDX_W'(i)))
               tog_q[i] <= ~tog_q[i];
         end

         // R5: a plane that is not addressed keeps its toggle state
         p_tog_other_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(adv_en && (adv_idx == PIDX_W'(i))) |=> $stable(tog_q[i]));
      end
   endgenerate
endmodule

// File: rtl/opstat_word_build.sv
module opstat_word_build
   import opstat_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6,
   parameter int AUX_BIT  = 2
) (
   input  rd_mode_e          mode,
   input  logic              tog,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [DATA_W-1:0] prog_data,
   output logic [DATA_W-1:0] word
);
   logic poll_v, tog_v, aux_v;

   always_comb begin
      poll_v = arr_data[POLL_BIT];
      tog_v  = arr_data[TOG_BIT];
      aux_v  = arr_data[AUX_BIT];
      unique case (mode)
         MODE_PROG: begin
            poll_v = ~prog_data[POLL_BIT];
            tog_v  = tog;
            aux_v  = 1'b1;
         end
         MODE_ERASE: begin
            poll_v = 1'b0;
            tog_v  = tog;
            aux_v  = tog;
         end
         MODE_SUSP: begin
            poll_v = 1'b1;
            tog_v  = 1'b1;
            aux_v  = tog;
         end
         default: ;
      endcase
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign word[b] = poll_v;
         end else if (b == TOG_BIT) begin : g_tog
            assign word[b] = tog_v;
         end else if (b == AUX_BIT) begin : g_aux
            assign word[b] = aux_v;
         end else begin : g_pass
            assign word[b] = arr_data[b];
         end
      end
   endgenerate
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
   import opstat_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter int PLANE_BITS   = 1,
   parameter int SECTOR_SHIFT = 15,
   parameter int POLL_BIT     = 7,
   parameter int TOG_BIT      = 6,
   parameter int AUX_BIT      = 2,
   localparam int NP          = 1 << PLANE_BITS,
   localparam int PIDX_W      = (PLANE_BITS > 0) ? PLANE_BITS : 1,
   localparam int SECT_W      = ADDR_W - SECTOR_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [NP-1:0]     plane_prog,
   input  logic [NP-1:0]     plane_erase,
   input  logic [NP-1:0]     plane_susp,
   input  logic [DATA_W-1:0] prog_data,
   input  logic [SECT_W-1:0] susp_sector,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              busy_n
);
   generate
      if (DATA_W <= POLL_BIT || DATA_W <= TOG_BIT || DATA_W <= AUX_BIT) begin : g_bad_bits
         $error("status bit position outside data word");
      end
      if (POLL_BIT == TOG_BIT || POLL_BIT == AUX_BIT || TOG_BIT == AUX_BIT) begin : g_dup_bits
         $error("status bit positions must differ");
      end
      if (SECTOR_SHIFT < 1 || SECTOR_SHIFT + PLANE_BITS > ADDR_W) begin : g_bad_sect
         $error("sector shift leaves no room for plane bits");
      end
   endgenerate

   logic [PIDX_W-1:0] plane_idx;
   rd_mode_e          mode;
   logic [NP-1:0]     tog_q;
   logic [DATA_W-1:0] word;
   logic              adv_en;

   opstat_plane_decode #(
      .ADDR_W(ADDR_W), .PLANE_BITS(PLANE_BITS), .SECTOR_SHIFT(SECTOR_SHIFT)
   ) u_decode (
      .rd_addr(rd_addr), .susp_sector(susp_sector),
      .plane_prog(plane_prog), .plane_erase(plane_erase), .plane_susp(plane_susp),
      .plane_idx(plane_idx), .mode(mode)
   );

   assign adv_en = rd_en && (mode != MODE_ARRAY);

   opstat_toggle_bank #(.NP(NP), .PIDX_W(PIDX_W)) u_toggles (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .adv_idx(plane_idx), .tog_q(tog_q)
   );

   opstat_word_build #(
      .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT), .AUX_BIT(AUX_BIT)
   ) u_build (
      .mode(mode), .tog(tog_q[plane_idx]), .arr_data(arr_data),
      .prog_data(prog_data), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
         busy_n   <= 1'b1;
      end else begin
         rd_valid <= rd_en;
         busy_n   <= ~|(plane_prog | plane_erase);
         if (rd_en)
            rd_data <= word;
      end
   end

   // cycles since reset guard for the $past checks below
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (rd_valid == $past(rd_en)));

   p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(rd_en)) |-> $stable(rd_data));

   p_busy_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(|(plane_prog | plane_erase))) |-> !busy_n);

   p_busy_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(|(plane_prog | plane_erase))) |-> busy_n);

   p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(rd_en && mode == MODE_ERASE)) |-> !rd_data[POLL_BIT]);

   p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(rd_en && mode == MODE_PROG))
         |-> (rd_data[POLL_BIT] != $past(prog_data[POLL_BIT])) && rd_data[AUX_BIT]);

   p_susp_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(rd_en && mode == MODE_SUSP))
         |-> rd_data[POLL_BIT] && rd_data[TOG_BIT]);

   p_array_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(rd_en && mode == MODE_ARRAY)) |-> (rd_data == $past(arr_data)));
endmodule

// File: tb/opstat_reporter_tb.sv
module opstat_reporter_tb_top;
   localparam int ADDR_W = 20;
   localparam int DATA_W = 16;
   localparam int NP     = 2;
   localparam int SECT_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] arr_data = '0;
   logic [NP-1:0]     plane_prog = '0;
   logic [NP-1:0]     plane_erase = '0;
   logic [NP-1:0]     plane_susp = '0;
   logic [DATA_W-1:0] prog_data = '0;
   logic [SECT_W-1:0] susp_sector = '0;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid;
   logic              busy_n;

   int total = 0;
   int bad   = 0;
   logic [NP-1:0] m_tog = '0;

   always #10 clk = ~clk;

   opstat_reporter dut_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data),
      .plane_prog(plane_prog), .plane_erase(plane_erase), .plane_susp(plane_susp),
      .prog_data(prog_data), .susp_sector(susp_sector),
      .rd_data(rd_data), .rd_valid(rd_valid), .busy_n(busy_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // 0 array, 1 program, 2 erase, 3 suspended-sector read
   function automatic int mode_of(input logic [ADDR_W-1:0] a);
      int p = int'(a[19]);
      if (plane_prog[p]) return 1;
      if (plane_erase[p]) return 2;
      if (plane_susp[p] && a[19:15] == susp_sector) return 3;
      return 0;
   endfunction

   function automatic logic [DATA_W-1:0] exp_word(input int md, input logic t,
                                                  input logic [DATA_W-1:0] arr);
      logic [DATA_W-1:0] w = arr;
      case (md)
         1: begin w[7] = ~prog_data[7]; w[6] = t; w[2] = 1'b1; end
         2: begin w[7] = 1'b0; w[6] = t; w[2] = t; end
         3: begin w[7] = 1'b1; w[6] = 1'b1; w[2] = t; end
         default: ;
      endcase
      return w;
   endfunction

   task automatic set_flags(input logic [1:0] p, input logic [1:0] e, input logic [1:0] s,
                            input logic [SECT_W-1:0] sec, input logic [DATA_W-1:0] pd);
      @(negedge clk);
      plane_prog = p; plane_erase = e; plane_susp = s; susp_sector = sec; prog_data = pd;
      @(negedge clk);
      check("R11 busy_n", 32'(busy_n), 32'(~|(p | e)));
   endtask

   task automatic do_read(input string req, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] arr);
      int md; int p; logic [DATA_W-1:0] ew;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; arr_data = arr;
      md = mode_of(a); p = int'(a[19]);
      ew = exp_word(md, m_tog[p], arr);
      if (md != 0) m_tog[p] = ~m_tog[p];
      @(negedge clk);
      rd_en = 1'b0;
      check({req, " rd_valid R10"}, 32'(rd_valid), 32'd1);
      check(req, 32'(rd_data), 32'(ew));
      @(negedge clk);
      check("R10 valid drops", 32'(rd_valid), 32'd0);
      check("R10 data held", 32'(rd_data), 32'(ew));
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 rd_valid", 32'(rd_valid), 32'd0);
      check("R1 rd_data", 32'(rd_data), 32'd0);
      check("R1 busy_n", 32'(busy_n), 32'd1);
      rst_n = 1'b1;

      // R6 idle reads pass through both planes
      do_read("R6 idle plane0", 20'h01234, 16'hA5C3);
      do_read("R6 idle plane1", 20'h8ABCD, 16'h3C5A);
      // R3 program in plane 1, R5 first status read gives bit6=0 then toggles
      set_flags(2'b10, 2'b00, 2'b00, '0, 16'h0080);
      do_read("R3 R5 prog first", 20'h80010, 16'hFFFF);
      do_read("R3 R5 prog second", 20'h80010, 16'hFFFF);
      do_read("R6 R2 other plane idle", 20'h00010, 16'h1234);
      // R9 passthrough bits in status word
      do_read("R9 prog word", 20'h9F00F, 16'h5A5A);
      // R4 erase in plane 0, prog still in plane 1
      set_flags(2'b10, 2'b01, 2'b00, '0, 16'h0000);
      do_read("R4 erase a", 20'h10000, 16'hFFFF);
      do_read("R4 erase b", 20'h10000, 16'hFFFF);
      do_read("R5 plane1 own toggle", 20'hC0000, 16'h0000);
      // R3 precedence: program outranks erase
      set_flags(2'b01, 2'b01, 2'b00, '0, 16'h00FF);
      do_read("R3 precedence", 20'h00002, 16'h0F0F);
      // R7 R8 suspend in plane 1, sector 5'h13
      set_flags(2'b00, 2'b00, 2'b10, 5'h13, 16'h0000);
      do_read("R7 susp hit", 20'h98765, 16'h0000);
      do_read("R7 susp hit again", 20'h9FFFF, 16'h0000);
      do_read("R8 susp miss", 20'hA0000, 16'h00C4);
      do_read("R4 done true data", 20'h10000, 16'hBEEF);
      set_flags(2'b00, 2'b00, 2'b00, '0, 16'h0000);
      do_read("R5 stopped toggling", 20'h80010, 16'h4444);

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         if (it % 8 == 0) begin
            logic [1:0] p = '0, e = '0, s = '0;
            logic [SECT_W-1:0] sec;
            for (int k = 0; k < NP; k++) begin
               int st = int'($urandom_range(0, 3));
               if (st == 1) p[k] = 1'b1;
               if (st == 2) e[k] = 1'b1;
               if (st == 3 && s == '0) s[k] = 1'b1;
               if ($urandom_range(0, 5) == 0) begin p[k] = 1'b1; e[k] = 1'b1; end
            end
            sec = 5'($urandom_range(0, 31));
            if (s[0]) sec[4] = 1'b0;
            if (s[1]) sec[4] = 1'b1;
            set_flags(p, e, s, sec, 16'($urandom));
         end
         begin
            logic [ADDR_W-1:0] a = 20'($urandom);
            if ($urandom_range(0, 1) == 1) a[19:15] = susp_sector;
            do_read("R2-mix random read", a, 16'($urandom));
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule